// File: doc/BRIEF.md
# Fractional DSP MAC ALU

This block is the execute stage of a 32-bit audio signal processor. Each accepted operation takes a 4-bit opcode and three signed two's-complement operands A, X and Y. One clock edge later it presents a 32-bit result R and a 9-bit condition word. The opcodes cover Q31 fractional multiply-accumulate, integer multiply-accumulate, three-input addition, bitwise logic, signed compare-select and linear interpolation. The fractional and integer forms come in saturating and wrapping variants.

A separate accumulator register is never written through R. It changes only under the move-and-accumulate opcode, which returns A unchanged and adds the Q31 product of X and Y into the accumulator in the same step. Opcodes 12, 13 and 15 are decoded. They only forward A here, because their sequencing effect belongs to the instruction sequencer. Internally, products are formed at 64 bits before any shift, so no intermediate value is lost before saturation or wrap.

Top module: `dsp_mac_alu`

## Requirements
- R1: After reset, `out_valid`, `r`, `cc` and `acc` are all zero.
- R2: An operation presented with `in_valid` high appears on `r`/`cc` with `out_valid` high exactly one clock later. `out_valid` is low in every cycle that follows a cycle without `in_valid`.
- R3: Opcodes 0 to 3 give R = A + (P >>> 31), where P is the exact 64-bit product X·Y (opcodes 0, 2) or its negation −X·Y (opcodes 1, 3), and >>> is an arithmetic shift. Opcodes 0 and 1 saturate; opcodes 2 and 3 keep the low 32 bits.
- R4: Opcode 4 gives A + X·Y as an integer sum, saturated to 32 bits.
- R5: Opcode 5 gives A + X·Y wrapped to 31 bits: the low 31 bits of the exact sum, sign-extended from bit 30.
- R6: Opcode 6 gives A + X + Y, saturated.
- R7: Opcode 7 gives R = A, and adds (X·Y >>> 31) modulo 2^32 into the accumulator.
- R8: The accumulator keeps its value under every opcode other than 7 and in idle cycles.
- R9: Opcode 8 gives (A AND X) XOR Y.
- R10: With a signed comparison, opcode 9 gives X if A ≥ Y and otherwise NOT X. Opcode 10 gives X if A ≥ Y and otherwise Y. Opcode 11 gives X if A < Y and otherwise Y.
- R11: Opcode 14 gives A + ((X·(Y − A)) >>> 31), saturated, with the difference and the product kept exact.
- R12: Opcodes 12, 13 and 15 give R = A.
- R13: Saturation clamps to 0x7FFFFFFF above the range and to 0x80000000 below it, and sets `cc` bit 4. Bit 4 is clear for every result that is not clamped.
- R14: `cc` bit 0 is R[31] XOR R[30]; bit 1 is set when A < Y compared unsigned; bit 2 is R[31]; bit 3 is set when R is zero; bit 8 is set when R is non-zero. Bits 5 to 7 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode |
| a | input | 32 | Operand A |
| x | input | 32 | Operand X |
| y | input | 32 | Operand Y |
| out_valid | output | 1 | Result registers hold a new result |
| r | output | 32 | Result |
| cc | output | 9 | Condition word |
| acc | output | 32 | Accumulator |

## Verification
The assertions watch, on every cycle, the one-cycle handshake, the hold of the accumulator outside opcode 7, the forwarding of A by the pass-through opcodes, and two properties of the results: a raised saturate flag always comes with one of the two clamp values, and a compare-select result is always one of its candidates. The bench's scenarios are needed for the arithmetic itself. They cover exact Q31 rounding of negative products, the product of two −1.0 values overflowing into saturation or wrap, the 31-bit sign-extension of opcode 5, and interpolation at its end points. They also cover accumulator values built up over a series of opcode-7 steps with idle gaps between them.

// File: rtl/dsp_mac_alu.sv
module dsp_mac_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         out_valid,
  output logic [W-1:0] r,
  output logic [8:0]   cc,
  output logic [W-1:0] acc
);
  localparam int WW = 2 * W;
  localparam int SH = W - 1;
  localparam logic signed [WW-1:0] MAXV = (WW'(1) <<< (W - 1)) - WW'(1);
  localparam logic signed [WW-1:0] MINV = -MAXV - WW'(1);

  typedef enum logic [1:0] {K_SAT, K_WRAP, K_WRAP31, K_DIRECT} kind_t;

  logic signed [WW-1:0] as, xs, ys, pxy, frac, fneg, ip, wide;
  kind_t kind;
  logic [W-1:0] res;
  logic satf;
  logic ge_s;
  logic [8:0] ccn;

  assign as   = {{W{a[W-1]}}, a};
  assign xs   = {{W{x[W-1]}}, x};
  assign ys   = {{W{y[W-1]}}, y};
  assign pxy  = xs * ys;
  assign frac = pxy >>> SH;
  assign fneg = (-pxy) >>> SH;
  assign ip   = (xs * (ys - as)) >>> SH;
  assign ge_s = $signed(a) >= $signed(y);

  always_comb begin
    wide = as;
    kind = K_DIRECT;
    case (op)
      4'd0:  begin wide = as + frac;    kind = K_SAT;    end
      4'd1:  begin wide = as + fneg;    kind = K_SAT;    end
      4'd2:  begin wide = as + frac;    kind = K_WRAP;   end
      4'd3:  begin wide = as + fneg;    kind = K_WRAP;   end
      4'd4:  begin wide = as + pxy;     kind = K_SAT;    end
      4'd5:  begin wide = as + pxy;     kind = K_WRAP31; end
      4'd6:  begin wide = as + xs + ys; kind = K_SAT;    end
      4'd14: begin wide = as + ip;      kind = K_SAT;    end
      default: ;
    endcase
  end

  always_comb begin
    satf = 1'b0;
    res  = a;
    case (kind)
      K_SAT: begin
        if (wide > MAXV) begin
          res = MAXV[W-1:0]; satf = 1'b1;
        end else if (wide < MINV) begin
          res = MINV[W-1:0]; satf = 1'b1;
        end else begin
          res = wide[W-1:0];
        end
      end
      K_WRAP:   res = wide[W-1:0];
      K_WRAP31: res = {wide[W-2], wide[W-2:0]};
      default: begin
        case (op)
          4'd8:    res = (a & x) ^ y;
          4'd9:    res = ge_s ? x : ~x;
          4'd10:   res = ge_s ? x : y;
          4'd11:   res = ge_s ? y : x;
          default: res = a;
        endcase
      end
    endcase
  end

  always_comb begin
    ccn    = '0;
    ccn[0] = res[W-1] ^ res[W-2];
    ccn[1] = a < y;
    ccn[2] = res[W-1];
    ccn[3] = (res == '0);
    ccn[4] = satf;
    ccn[8] = (res != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      r         <= '0;
      cc        <= '0;
      acc       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        r  <= res;
        cc <= ccn;
        if (op == 4'd7) acc <= acc + frac[W-1:0];
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || op != 4'd7) |=> $stable(acc));
  p_macmv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd7 && x == '0) |=> ($stable(acc) && r == $past(a)));
  p_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd12 || op == 4'd13 || op == 4'd15)) |=> r == $past(a));
  p_clamp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cc[4]) |-> (r == MAXV[W-1:0] || r == MINV[W-1:0]));
  p_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd10 || op == 4'd11)) |=> (r == $past(x) || r == $past(y)));
endmodule

// File: tb/dsp_mac_alu_bench.sv
`timescale 1ns/1ps
module dsp_mac_alu_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [31:0] a = '0, x = '0, y = '0;
  logic out_valid;
  logic [31:0] r, acc;
  logic [8:0] cc;

  int checks = 0;
  int errors = 0;
  logic [31:0] acc_m = '0;
  bit done = 1'b0;

  typedef struct packed {
    logic [31:0] r;
    logic [8:0]  cc;
    logic [31:0] acc;
    logic [3:0]  op;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  dsp_mac_alu u_dsp_mac_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .x(x), .y(y),
    .out_valid(out_valid), .r(r), .cc(cc), .acc(acc)
  );

  function automatic logic [31:0] clamp(input longint v, output bit s);
    s = 1'b0;
    if (v > 64'sd2147483647) begin s = 1'b1; return 32'h7FFF_FFFF; end
    if (v < -64'sd2147483648) begin s = 1'b1; return 32'h8000_0000; end
    return v[31:0];
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, want);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [31:0] va, input logic [31:0] vx, input logic [31:0] vy);
    longint la, lx, ly, p, t;
    bit s;
    exp_t e;
    logic [31:0] rr;
    la = longint'(signed'(va)); lx = longint'(signed'(vx)); ly = longint'(signed'(vy));
    p = lx * ly;
    s = 1'b0;
    rr = va;
    if (o == 0)       rr = clamp(la + (p >>> 31), s);
    else if (o == 1)  rr = clamp(la + ((-p) >>> 31), s);
    else if (o == 2)  begin t = la + (p >>> 31); rr = t[31:0]; end
    else if (o == 3)  begin t = la + ((-p) >>> 31); rr = t[31:0]; end
    else if (o == 4)  rr = clamp(la + p, s);
    else if (o == 5)  begin t = la + p; rr = {t[30], t[30:0]}; end
    else if (o == 6)  rr = clamp(la + lx + ly, s);
    else if (o == 7)  begin t = p >>> 31; acc_m = acc_m + t[31:0]; end
    else if (o == 8)  rr = (va & vx) ^ vy;
    else if (o == 9)  rr = (la >= ly) ? vx : ~vx;
    else if (o == 10) rr = (la >= ly) ? vx : vy;
    else if (o == 11) rr = (la < ly) ? vx : vy;
    else if (o == 14) rr = clamp(la + ((lx * (ly - la)) >>> 31), s);
    e.r = rr;
    e.cc = {(rr != 0), 3'b000, s, (rr == 0), rr[31], (va < vy), rr[31] ^ rr[30]};
    e.acc = acc_m;
    e.op = o;
    @(negedge clk);
    in_valid = 1'b1; op = o; a = va; x = vx; y = vy;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op = 4'd7; x = 32'h4000_0000; y = 32'h4000_0000;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check("R2 unexpected out_valid", 64'(out_valid), 64'd0);
      end else begin
        exp_t e;
        string tag;
        e = q.pop_front();
        case (e.op)
          4'd0, 4'd1, 4'd2, 4'd3: tag = "R3";
          4'd4:  tag = "R4";
          4'd5:  tag = "R5";
          4'd6:  tag = "R6";
          4'd7:  tag = "R7";
          4'd8:  tag = "R9";
          4'd9, 4'd10, 4'd11: tag = "R10";
          4'd14: tag = "R11";
          default: tag = "R12";
        endcase
        check({tag, " result"}, 64'(r), 64'(e.r));
        check("R13/R14 cc", 64'(cc), 64'(e.cc));
        check(e.op == 4'd7 ? "R7 acc" : "R8 acc", 64'(acc), 64'(e.acc));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", 64'(out_valid), 0);
    check("R1 r", 64'(r), 0);
    check("R1 cc", 64'(cc), 0);
    check("R1 acc", 64'(acc), 0);
    rst_n = 1'b1;
    // R3 fractional forms
    issue(0, 32'h1000_0000, 32'h4000_0000, 32'h4000_0000);
    issue(0, 32'h7FFF_FFFF, 32'h4000_0000, 32'h4000_0000);
    issue(1, 32'h0000_0000, 32'h4000_0000, 32'h4000_0000);
    issue(1, 32'h8000_0000, 32'h4000_0000, 32'h4000_0000);
    issue(0, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000);
    issue(2, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000);
    issue(2, 32'h7FFF_FFFF, 32'h4000_0000, 32'h4000_0000);
    issue(3, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001);
    issue(1, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0003);
    // R4, R5, R6
    issue(4, 32'h0000_0010, 32'h0000_0003, 32'hFFFF_FFFB);
    issue(4, 32'h0000_0000, 32'h0001_0000, 32'h0001_0000);
    issue(4, 32'h0000_0000, 32'h0001_0000, 32'hFFFF_0000);
    issue(5, 32'h3FFF_FFFF, 32'h0000_0001, 32'h0000_0001);
    issue(5, 32'h0000_0005, 32'h0000_0002, 32'h0000_0003);
    issue(6, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(6, 32'h0000_0001, 32'h0000_0002, 32'hFFFF_FFFD);
    // R7 and R8: accumulate with gaps
    issue(7, 32'h1234_5678, 32'h4000_0000, 32'h4000_0000);
    idle(3);
    issue(7, 32'hCAFE_0000, 32'h4000_0000, 32'hC000_0000);
    issue(7, 32'h0000_0001, 32'h8000_0000, 32'h8000_0000);
    issue(7, 32'h0000_0002, 32'h8000_0000, 32'h8000_0000);
    idle(2);
    // R9, R10
    issue(8, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0F0F_0000);
    issue(9, 32'h0000_0005, 32'h1234_5678, 32'h0000_0005);
    issue(9, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0001);
    issue(10, 32'h0000_0001, 32'hAAAA_AAAA, 32'hFFFF_FFFF);
    issue(10, 32'h8000_0000, 32'hAAAA_AAAA, 32'h0000_0000);
    issue(11, 32'h8000_0000, 32'h1111_1111, 32'h7FFF_FFFF);
    issue(11, 32'h0000_0007, 32'h1111_1111, 32'h0000_0007);
    // R11 interpolation end points and overflow
    issue(14, 32'h1000_0000, 32'h0000_0000, 32'h7000_0000);
    issue(14, 32'h1000_0000, 32'h7FFF_FFFF, 32'h7000_0000);
    issue(14, 32'h1000_0000, 32'h4000_0000, 32'h3000_0000);
    issue(14, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF);
    // R12 pass-through
    issue(12, 32'hDEAD_BEEF, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    issue(13, 32'h0000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    issue(15, 32'h4000_0000, 32'h1, 32'h2);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rx, ry;
      ra = $urandom; rx = $urandom; ry = $urandom;
      if (i % 7 == 0) rx = 32'h8000_0000;
      if (i % 11 == 0) ra = 32'h7FFF_FFFF;
      issue(4'($urandom_range(0, 15)), ra, rx, ry);
      if (i % 13 == 0) idle(1);
    end
    idle(3);
    check("R2 queue drained", 64'(q.size()), 0);
    check("R2 out_valid idle", 64'(out_valid), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule